// File: doc/BRIEF.md
# Address-Event Serializer with RAM Queue

This block sits between a spike generator and a slow bit-serial channel toward an implanted electrode array. Each spike arrives as a single-cycle valid strobe carrying the address of the target electrode. At most one arrives per clock. The block stores only that address; no time information travels with it, and an event is sent as soon as the channel allows. Addresses are held in a queue built on a two-port RAM, written on one port and read on the other. The head of the queue is copied into a framing shift register, which drives the serial line. A read cannot disturb a word that is still going out.

The serial channel is much slower than the core clock, so the bit rate sets the event throughput and the queue absorbs bursts. A frame is one low start bit, then the address MSB first, then one high stop bit. Each bit is held for a programmable number of core clocks. The cost of the block does not grow with the number of electrodes, apart from the address width. The price of this is that an event may wait behind every other queued event. When the queue is full, further events are discarded and a sticky overflow flag is raised. A dedicated input clears this flag.

Top module: `aer_serializer`

## Requirements
- R1: While reset is asserted and after it is released with no events, `tx_o` is 1 and `ovf_o` is 0.
- R2: A frame is a start bit of 0, then the ADDR_W address bits with the MSB first, then a stop bit of 1. Each bit lasts exactly BIT_DIV clock cycles (BIT_DIV >= 2).
- R3: An event that arrives while the queue holds DEPTH entries is discarded and sets `ovf_o` at the next edge. When a burst of one event per cycle reaches an idle block, the first DEPTH+1 events are kept: DEPTH in the queue and one in the shift register.
- R4: Every accepted event is sent exactly once, and in the order of arrival.
- R5: With an idle line and an empty queue, `tx_o` is still 1 after the edge that captures an event and after the next edge. It is 0 (start bit) after the second edge.
- R6: When the queue is not empty at the end of a stop bit, the next start bit follows without a gap. The distance from start to start is (ADDR_W+2)*BIT_DIV cycles.
- R7: `ovf_o` stays set until `ovf_clr_i` is sampled high, and it is then 0 after that edge. If a discard and a clear fall in the same cycle, the flag stays set.
- R8: With no events the line stays high. A cycle with `ev_valid_i` low queues nothing, whatever is on `ev_addr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Spike event strobe, one event per cycle at most |
| ev_addr_i | input | ADDR_W | Target electrode address of the event |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| tx_o | output | 1 | Serial line, idles high |
| ovf_o | output | 1 | Sticky flag: an event was discarded |

## Verification
The bench decodes frames from the line with all-zero, all-one and alternating addresses. A design that shifted LSB first, or framed with the wrong polarity, would return mirrored or shifted words. A burst one event longer than the capacity targets the off-by-one at full. A design that kept the extra word, or that lost a word at the wrap of the pointers, would show a missing, repeated or reordered address. The bench measures the start-to-start spacing of queued frames and the idle-to-start latency, which exposes a reload that leaves a dead cycle or that overwrites the shift register early. It also checks the case where a clear and a discard fall in the same cycle, where a wrong priority would lose the overflow indication.

// File: rtl/aer_pkg.sv
package aer_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/aer_dpram.sv
module aer_dpram #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/aer_fifo.sv
module aer_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_valid_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         ovf_clr_i,
  input  logic         rd_req_i,
  output logic         rd_ack_o,
  output logic         rd_vld_o,
  output logic [W-1:0] rd_data_o,
  output logic         ovf_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wr_ptr_q, rd_ptr_q, fill;
  logic          full, empty, do_wr, rd_vld_q, ovf_q;

  // extra wrap bit tells full from empty
  assign empty    = (wr_ptr_q == rd_ptr_q);
  assign full     = (wr_ptr_q[PW-1] != rd_ptr_q[PW-1]) &&
                    (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign do_wr    = wr_valid_i && !full;
  assign rd_ack_o = rd_req_i && !empty;
  assign fill     = wr_ptr_q - rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      rd_vld_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_wr)    wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_ack_o) rd_ptr_q <= rd_ptr_q + 1'b1;
      rd_vld_q <= rd_ack_o;
      // discard has priority over clear
      if (wr_valid_i && full) ovf_q <= 1'b1;
      else if (ovf_clr_i)     ovf_q <= 1'b0;
    end
  end

  aer_dpram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk_i    (clk_i),
    .wr_en_i  (do_wr),
    .wr_addr_i(wr_ptr_q[AW-1:0]),
    .wr_data_i(wr_data_i),
    .rd_en_i  (rd_ack_o),
    .rd_addr_i(rd_ptr_q[AW-1:0]),
    .rd_data_o(rd_data_o)
  );

  assign rd_vld_o = rd_vld_q;
  assign ovf_o    = ovf_q;

  p_drop_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full) |=> $stable(wr_ptr_q));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full) |=> ovf_o);
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  p_ovf_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(wr_valid_i && full)) |=> !ovf_o);
  p_fill_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= PW'(DEPTH));
  p_idle_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(wr_ptr_q));
endmodule

// File: rtl/aer_tx.sv
module aer_tx
  import aer_pkg::*;
#(
  parameter int unsigned W       = 10,
  parameter int unsigned BIT_DIV = 50
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_vld_i,
  input  logic [W-1:0] rd_data_i,
  output logic         rd_req_o,
  output logic         tx_o
);
  localparam int unsigned FW = W + 2;
  localparam int unsigned DW = $clog2(BIT_DIV);
  localparam int unsigned BW = $clog2(FW);

  tx_state_e      state_q;
  logic [FW-1:0]  frame_q;
  logic [DW-1:0]  div_q;
  logic [BW-1:0]  bit_q;
  logic           last_div, stop_bit, frame_end, early_req;

  assign last_div  = (div_q == DW'(BIT_DIV - 1));
  assign stop_bit  = (bit_q == BW'(FW - 1));
  assign frame_end = (state_q == TX_SEND) && last_div && stop_bit;
  // ask one cycle before stop ends so RAM latency is hidden
  assign early_req = (state_q == TX_SEND) && stop_bit &&
                     (div_q == DW'(BIT_DIV - 2));
  assign rd_req_o  = ((state_q == TX_IDLE) && !rd_vld_i) || early_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      frame_q <= '1;
      div_q   <= '0;
      bit_q   <= '0;
    end else if (rd_vld_i) begin
      state_q <= TX_SEND;
      frame_q <= {1'b0, rd_data_i, 1'b1};
      div_q   <= '0;
      bit_q   <= '0;
    end else if (state_q == TX_SEND) begin
      if (last_div) begin
        div_q   <= '0;
        frame_q <= {frame_q[FW-2:0], 1'b1};
        if (stop_bit) begin
          state_q <= TX_IDLE;
          bit_q   <= '0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign tx_o = (state_q == TX_SEND) ? frame_q[FW-1] : 1'b1;

  p_start_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_i |=> !tx_o);
  p_stop_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == TX_SEND) && stop_bit) |-> tx_o);
  p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == TX_SEND) && !last_div && !rd_vld_i) |=> $stable(tx_o));
  p_reload_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vld_i && (state_q == TX_SEND)) |-> frame_end);
endmodule

// File: rtl/aer_serializer.sv
module aer_serializer #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned BIT_DIV = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic              ovf_clr_i,
  output logic              tx_o,
  output logic              ovf_o
);
  logic              rd_req, rd_ack, rd_vld;
  logic [ADDR_W-1:0] rd_data;

  aer_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_valid_i(ev_valid_i),
    .wr_data_i (ev_addr_i),
    .ovf_clr_i (ovf_clr_i),
    .rd_req_i  (rd_req),
    .rd_ack_o  (rd_ack),
    .rd_vld_o  (rd_vld),
    .rd_data_o (rd_data),
    .ovf_o     (ovf_o)
  );

  aer_tx #(.W(ADDR_W), .BIT_DIV(BIT_DIV)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_vld_i (rd_vld),
    .rd_data_i(rd_data),
    .rd_req_o (rd_req),
    .tx_o     (tx_o)
  );

  p_one_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack |=> !rd_ack);
endmodule

// File: tb/sim_aer_serializer.sv
module sim_aer_serializer;
  localparam int AW = 10;
  localparam int D  = 8;
  localparam int BD = 4;
  localparam int FRAME_CYC = (AW + 2) * BD;
  localparam int NV = 6;
  // {stimulus address, expected decoded word}
  localparam logic [2*AW-1:0] VEC [NV] = '{
    {10'h000, 10'h000}, {10'h3FF, 10'h3FF}, {10'h2AA, 10'h2AA},
    {10'h155, 10'h155}, {10'h001, 10'h001}, {10'h200, 10'h200}
  };

  logic clk = 1'b0, rst_n = 1'b0, ev_valid = 1'b0, ovf_clr = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic tx, ovf;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aer_serializer #(.ADDR_W(AW), .DEPTH(D), .BIT_DIV(BD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_addr_i(ev_addr),
    .ovf_clr_i(ovf_clr), .tx_o(tx), .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_addr  = a;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic rx_frame(output logic [AW-1:0] w, output logic st, output logic sp,
                          output int t0);
    while (tx !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (BD / 2) @(negedge clk);
    st = tx;
    for (int i = 0; i < AW; i++) begin
      repeat (BD) @(negedge clk);
      w[AW-1-i] = tx;
    end
    repeat (BD) @(negedge clk);
    sp = tx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] w;
    logic st, sp;
    int t0, tprev;
    bit hi;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(tx === 1'b1, "R1 tx in reset", int'(tx), 1);
    check(ovf === 1'b0, "R1 ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx === 1'b1 && ovf === 1'b0, "R1 after reset", int'({tx, ovf}), 2);

    // R8 invalid cycles queue nothing
    ev_addr = 10'h0F0;
    hi = 1'b1;
    repeat (3 * FRAME_CYC) begin
      @(negedge clk);
      ev_addr = ~ev_addr;
      if (tx !== 1'b1) hi = 1'b0;
    end
    check(hi, "R8 idle line with ev_valid low", int'(hi), 1);

    // R2 table of frames
    for (int v = 0; v < NV; v++) begin
      fork
        send(VEC[v][2*AW-1:AW]);
        rx_frame(w, st, sp, t0);
      join
      check(st === 1'b0, "R2 start bit", int'(st), 0);
      check(w === VEC[v][AW-1:0], "R2 address MSB first", int'(w), int'(VEC[v][AW-1:0]));
      check(sp === 1'b1, "R2 stop bit", int'(sp), 1);
    end
    repeat (2 * BD) @(negedge clk);

    // R5 idle latency
    @(negedge clk);
    ev_valid = 1'b1;
    ev_addr  = 10'h0C3;
    @(negedge clk);
    ev_valid = 1'b0;
    check(tx === 1'b1, "R5 high after capture edge", int'(tx), 1);
    @(negedge clk);
    check(tx === 1'b1, "R5 high after next edge", int'(tx), 1);
    @(negedge clk);
    check(tx === 1'b0, "R5 start after second edge", int'(tx), 0);
    repeat (FRAME_CYC + BD) @(negedge clk);

    // R6 back-to-back spacing, R4 order
    fork
      begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          ev_valid = 1'b1;
          ev_addr  = AW'(10'h011 * (k + 1));
        end
        @(negedge clk);
        ev_valid = 1'b0;
      end
      begin
        tprev = 0;
        for (int k = 0; k < 3; k++) begin
          rx_frame(w, st, sp, t0);
          check(w === AW'(10'h011 * (k + 1)), "R4 burst order", int'(w), 10'h011 * (k + 1));
          if (k > 0) check(t0 - tprev == FRAME_CYC, "R6 start spacing", t0 - tprev, FRAME_CYC);
          tprev = t0;
        end
      end
    join
    repeat (2 * BD) @(negedge clk);

    // R3 capacity, R4 order after wrap, R7 set wins over clear
    fork
      begin
        for (int k = 0; k < D + 2; k++) begin
          @(negedge clk);
          ev_valid = 1'b1;
          ev_addr  = AW'(10'h100 + k);
          ovf_clr  = (k == D + 1);
        end
        @(negedge clk);
        ev_valid = 1'b0;
        ovf_clr  = 1'b0;
        check(ovf === 1'b1, "R7 discard beats clear", int'(ovf), 1);
      end
      begin
        for (int k = 0; k < D + 1; k++) begin
          rx_frame(w, st, sp, t0);
          check(w === AW'(10'h100 + k), "R3 kept event order", int'(w), 10'h100 + k);
        end
      end
    join
    // dropped event must not appear
    hi = 1'b1;
    repeat (2 * FRAME_CYC) begin
      @(negedge clk);
      if (tx !== 1'b1) hi = 1'b0;
    end
    check(hi, "R3 discarded event not sent", int'(hi), 1);
    check(ovf === 1'b1, "R7 flag sticky", int'(ovf), 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check(ovf === 1'b0, "R7 clear", int'(ovf), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule